// File: doc/BRIEF.md
# Shared-Pool Packet Switching Hub

This block is the central switching core for four byte-stream ports that share a single packet store. Each port hands over raw bytes, one per cycle, and keeps no copy of a packet or its header. The hub gives each new packet a slot in the shared store and writes the following bytes of that packet into the same slot. When the packet reaches the configured length, the hub reads the captured header and decides where the packet goes.

A forwarded packet is announced to its output port by a one-cycle notify strobe that carries the slot index. That port fetches bytes through its own read port. It hands the slot back with a done strobe once transmission is finished. Packets addressed to the hub itself are absorbed. When their command byte is zero they reprogram the packet length. A small number of slots is held back for these hub-bound packets. A congestion flag shared by all ports rises when only reserved slots remain.

Header layout: byte 0 is the destination and byte 1 is the command. When byte 1 is zero, bits [1:0] of byte 2 carry a new length code. Slot `s` holds its bytes at read offsets `0 .. length-1`.

Top module: `switch_hub`

## Requirements
- R1: After reset all slots are free, `congested` is low, `notify_valid` is zero and the length code is `DEF_SIZE` (default 0, meaning 64 bytes).
- R2: A valid byte on an idle port starts a packet. If a slot can be granted, the lowest-numbered free slot is taken, `rx_ready` is high for every byte of the packet, and byte k lands at offset k of that slot. A port's read port returns `mem[slot][offset]` one cycle after the address is presented.
- R3: If no slot can be granted to a starting packet, that packet is dropped. `rx_ready` stays low for all of its bytes and no notify is produced for it.
- R4: A packet is complete when its byte count equals the length latched at its first byte. The notify strobe is high for exactly one cycle and is one-hot across ports. With no other completion pending, it is visible in the cycle after the clock edge that follows the edge taking the last byte.
- R5: Destination byte values 1, 2, 3 and 4 select output ports 0, 1, 2 and 3. Any other non-zero value selects port 0. `notify_slot` carries the slot index.
- R6: A packet whose destination byte is 0 is consumed by the hub. It produces no notify, and its slot is free again from the cycle in which its notify would otherwise have appeared.
- R7: A consumed packet whose command byte is 0 sets the length code from bits [1:0] of byte 2. Codes 0, 1, 2 and 3 give 64, 128, 256 and 512 bytes. The new length applies only to packets that start afterwards.
- R8: `NRSV` slots (default 1) are held back. A packet with a non-zero destination is granted only while more than `NRSV` slots are free. A packet with destination 0 is granted while any slot is free.
- R9: `congested` is high exactly while the number of free slots is at most `NRSV`.
- R10: A `tx_done` pulse on any port with `tx_done_slot` returns that slot to the free pool for the next allocation.
- R11: Packets starting on several ports in the same cycle are granted in port order, lowest port first, each taking the lowest slot still free. Completions in the same cycle are announced one per cycle, lowest port first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 4 | Per-port byte valid |
| rx_data | input | 32 | Per-port byte, port i in bits [8i+7:8i] |
| rx_ready | output | 4 | Byte presented this cycle is stored |
| notify_valid | output | 4 | One-cycle strobe to the output port of a completed packet |
| notify_slot | output | SW | Slot index of the announced packet |
| tx_done | input | 4 | Per-port slot release strobe |
| tx_done_slot | input | 4*SW | Slot released by each port |
| rd_slot | input | 4*SW | Per-port read slot |
| rd_off | input | 4*OW | Per-port read offset |
| rd_data | output | 32 | Per-port read byte, registered |
| congested | output | 1 | Only reserved slots remain |

## Verification
The bench fills the normal slots until only the reserved slot is left. At that point a forwarded packet must be refused for its whole length, while a hub-bound packet must still be accepted. A design that ignored the reserve would forward into the last slot, and one that dropped only the first byte would raise `rx_ready` partway through the packet. A length change is checked by looking for the notify at byte 128 and not at byte 64; a design that applied the new length mid-packet, or ignored it, would announce at the wrong byte. Two packets finishing on the same edge must be announced on consecutive cycles in port order, so a hub that merged or lost one strobe is caught. The fallback route for an unknown destination and the reuse of a slot after a done strobe are also checked.

// File: rtl/hub_pkg.sv
package hub_pkg;

    localparam int HUB_PORTS = 4;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_STORE,
        RX_DROP
    } rx_state_e;

    // Destination byte to output port; 0 is consumed before this is used.
    function automatic logic [1:0] dest_to_port(input byte_t d);
        case (d)
            8'd1:    return 2'd0;
            8'd2:    return 2'd1;
            8'd3:    return 2'd2;
            8'd4:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/hub_slot_pool.sv
module hub_slot_pool
    import hub_pkg::*;
#(
    parameter int NSLOTS = 4,
    parameter int NRSV   = 1,
    parameter int NP     = HUB_PORTS,
    localparam int SW    = $clog2(NSLOTS),
    localparam int CW    = $clog2(NSLOTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NP-1:0]          req,
    input  logic [NP-1:0]          hub_dir,
    output logic [NP-1:0]          grant,
    output logic [NP-1:0][SW-1:0]  grant_slot,
    input  logic [NSLOTS-1:0]      rel_mask,
    output logic                   congested
);

    logic [NSLOTS-1:0] free_q;
    logic [NSLOTS-1:0] avail;
    logic [CW-1:0]     free_cnt;
    logic [CW-1:0]     left;
    logic [SW-1:0]     pick;

    always_comb begin
        free_cnt = '0;
        for (int s = 0; s < NSLOTS; s++) free_cnt = free_cnt + CW'(free_q[s]);
        avail      = free_q;
        left       = free_cnt;
        grant      = '0;
        grant_slot = '0;
        pick       = '0;
        for (int i = 0; i < NP; i++) begin
            if (req[i] && (left > CW'(NRSV) || (hub_dir[i] && left != '0))) begin
                pick = '0;
                for (int s = NSLOTS - 1; s >= 0; s--) if (avail[s]) pick = SW'(s);
                grant[i]      = 1'b1;
                grant_slot[i] = pick;
                avail[pick]   = 1'b0;
                left          = left - CW'(1);
            end
        end
    end

    assign congested = (free_cnt <= CW'(NRSV));

    always_ff @(posedge clk) begin
        if (rst) free_q <= '1;
        else     free_q <= avail | rel_mask;
    end

    // Released slots must be in use.
    assert_release_owned_R10: assert property (@(posedge clk) disable iff (rst)
        (rel_mask & free_q) == '0);

    generate
        for (genvar i = 0; i < NP; i++) begin : g_chk
            // Forwarded packets never take the reserved slots.
            assert_reserve_kept_R8: assert property (@(posedge clk) disable iff (rst)
                (congested && req[i] && !hub_dir[i]) |-> !grant[i]);
            for (genvar j = i + 1; j < NP; j++) begin : g_pair
                assert_distinct_grant_R11: assert property (@(posedge clk) disable iff (rst)
                    (grant[i] && grant[j]) |-> (grant_slot[i] != grant_slot[j]));
            end
        end
    endgenerate

endmodule

// File: rtl/hub_port_rx.sv
module hub_port_rx
    import hub_pkg::*;
#(
    parameter int NSLOTS   = 4,
    parameter int BASE_LEN = 64,
    localparam int SW      = $clog2(NSLOTS),
    localparam int OW      = $clog2(BASE_LEN * 8),
    localparam int LW      = OW + 1,
    localparam int AW      = SW + OW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  byte_t         data,
    input  logic [1:0]    size_code,
    input  logic          grant,
    input  logic [SW-1:0] grant_slot,
    output logic          req,
    output logic          hub_dir,
    output logic          ready,
    output logic          we,
    output logic [AW-1:0] waddr,
    output byte_t         wdata,
    output logic          done,
    output logic [SW-1:0] slot_q,
    output byte_t         dest_q,
    output byte_t         cmd_q,
    output byte_t         arg_q
);

    rx_state_e     st_q;
    logic [OW-1:0] cnt_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] len_new;
    logic          last;

    assign len_new = LW'(BASE_LEN) << size_code;
    assign last    = ({1'b0, cnt_q} == len_q - LW'(1));
    assign req     = valid && (st_q == RX_IDLE);
    assign hub_dir = (data == 8'd0);
    assign wdata   = data;

    always_comb begin
        we    = 1'b0;
        ready = 1'b0;
        done  = 1'b0;
        waddr = {slot_q, cnt_q};
        case (st_q)
            RX_IDLE: if (grant) begin
                we    = 1'b1;
                ready = 1'b1;
                waddr = {grant_slot, {OW{1'b0}}};
            end
            RX_STORE: if (valid) begin
                we    = 1'b1;
                ready = 1'b1;
                done  = last;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RX_IDLE;
            cnt_q  <= '0;
            len_q  <= '0;
            slot_q <= '0;
            dest_q <= '0;
            cmd_q  <= '0;
            arg_q  <= '0;
        end else if (valid) begin
            case (st_q)
                RX_IDLE: begin
                    len_q <= len_new;
                    cnt_q <= OW'(1);
                    if (grant) begin
                        slot_q <= grant_slot;
                        dest_q <= data;
                        st_q   <= RX_STORE;
                    end else begin
                        st_q <= RX_DROP;
                    end
                end
                RX_STORE: begin
                    cnt_q <= cnt_q + OW'(1);
                    if (cnt_q == OW'(1)) cmd_q <= data;
                    if (cnt_q == OW'(2)) arg_q <= data;
                    if (last) st_q <= RX_IDLE;
                end
                default: begin
                    cnt_q <= cnt_q + OW'(1);
                    if (last) st_q <= RX_IDLE;
                end
            endcase
        end
    end

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q != RX_IDLE) |-> ({1'b0, cnt_q} < len_q));

endmodule

// File: rtl/hub_pool_mem.sv
module hub_pool_mem
    import hub_pkg::*;
#(
    parameter int AW = 11,
    parameter int NP = HUB_PORTS,
    localparam int DEPTH = 1 << AW
) (
    input  logic                  clk,
    input  logic [NP-1:0]         we,
    input  logic [NP-1:0][AW-1:0] waddr,
    input  byte_t [NP-1:0]        wdata,
    input  logic [NP-1:0][AW-1:0] raddr,
    output byte_t [NP-1:0]        rdata
);

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NP; i++) begin
            if (we[i]) mem[waddr[i]] <= wdata[i];
            rdata[i] <= mem[raddr[i]];
        end
    end

endmodule

// File: rtl/hub_route_post.sv
module hub_route_post
    import hub_pkg::*;
#(
    parameter int NSLOTS         = 4,
    parameter int NP             = HUB_PORTS,
    parameter logic [1:0] DEF_SIZE = 2'd0,
    localparam int SW            = $clog2(NSLOTS),
    localparam int PW            = $clog2(NP)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NP-1:0]         done,
    input  logic [NP-1:0][SW-1:0] slot,
    input  byte_t [NP-1:0]        dest,
    input  byte_t [NP-1:0]        cmd,
    input  byte_t [NP-1:0]        arg,
    output logic [NP-1:0]         notify_valid,
    output logic [SW-1:0]         notify_slot,
    output logic [NSLOTS-1:0]     rel_mask,
    output logic [1:0]            size_code
);

    logic [NP-1:0]         pend_q;
    logic [NP-1:0][SW-1:0] pslot_q;
    byte_t [NP-1:0]        pdest_q;
    byte_t [NP-1:0]        pcmd_q;
    byte_t [NP-1:0]        parg_q;
    logic                  sel_v;
    logic [PW-1:0]         sel;

    always_comb begin
        sel_v = 1'b0;
        sel   = '0;
        for (int i = NP - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                sel_v = 1'b1;
                sel   = PW'(i);
            end
        end
        rel_mask = '0;
        if (sel_v && pdest_q[sel] == 8'd0) rel_mask[pslot_q[sel]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q       <= '0;
            pslot_q      <= '0;
            pdest_q      <= '0;
            pcmd_q       <= '0;
            parg_q       <= '0;
            notify_valid <= '0;
            notify_slot  <= '0;
            size_code    <= DEF_SIZE;
        end else begin
            notify_valid <= '0;
            if (sel_v) begin
                pend_q[sel] <= 1'b0;
                if (pdest_q[sel] != 8'd0) begin
                    notify_valid[dest_to_port(pdest_q[sel])] <= 1'b1;
                    notify_slot <= pslot_q[sel];
                end else if (pcmd_q[sel] == 8'd0) begin
                    size_code <= parg_q[sel][1:0];
                end
            end
            for (int i = 0; i < NP; i++) begin
                if (done[i]) begin
                    pend_q[i]  <= 1'b1;
                    pslot_q[i] <= slot[i];
                    pdest_q[i] <= dest[i];
                    pcmd_q[i]  <= cmd[i];
                    parg_q[i]  <= arg[i];
                end
            end
        end
    end

    assert_notify_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(notify_valid));

    assert_consume_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_v && pdest_q[sel] == 8'd0) |=> (notify_valid == '0));

endmodule

// File: rtl/switch_hub.sv
module switch_hub
    import hub_pkg::*;
#(
    parameter int NSLOTS           = 4,
    parameter int NRSV             = 1,
    parameter int BASE_LEN         = 64,
    parameter logic [1:0] DEF_SIZE = 2'd0,
    localparam int NP              = HUB_PORTS,
    localparam int SW              = $clog2(NSLOTS),
    localparam int OW              = $clog2(BASE_LEN * 8),
    localparam int AW              = SW + OW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NP-1:0]    rx_valid,
    input  logic [NP*8-1:0]  rx_data,
    output logic [NP-1:0]    rx_ready,
    output logic [NP-1:0]    notify_valid,
    output logic [SW-1:0]    notify_slot,
    input  logic [NP-1:0]    tx_done,
    input  logic [NP*SW-1:0] tx_done_slot,
    input  logic [NP*SW-1:0] rd_slot,
    input  logic [NP*OW-1:0] rd_off,
    output logic [NP*8-1:0]  rd_data,
    output logic             congested
);

    logic [NP-1:0]         req, hub_dir, grant, we, done;
    logic [NP-1:0][SW-1:0] grant_slot, slot;
    logic [NP-1:0][AW-1:0] waddr, raddr;
    byte_t [NP-1:0]        wdata, dest, cmd, arg, rdata;
    logic [NSLOTS-1:0]     route_rel, rel_mask;
    logic [1:0]            size_code;

    hub_slot_pool #(.NSLOTS(NSLOTS), .NRSV(NRSV), .NP(NP)) u_pool (
        .clk(clk), .rst(rst), .req(req), .hub_dir(hub_dir), .grant(grant),
        .grant_slot(grant_slot), .rel_mask(rel_mask), .congested(congested));

    generate
        for (genvar i = 0; i < NP; i++) begin : g_port
            hub_port_rx #(.NSLOTS(NSLOTS), .BASE_LEN(BASE_LEN)) u_rx (
                .clk(clk), .rst(rst), .valid(rx_valid[i]), .data(rx_data[i*8 +: 8]),
                .size_code(size_code), .grant(grant[i]), .grant_slot(grant_slot[i]),
                .req(req[i]), .hub_dir(hub_dir[i]), .ready(rx_ready[i]), .we(we[i]),
                .waddr(waddr[i]), .wdata(wdata[i]), .done(done[i]), .slot_q(slot[i]),
                .dest_q(dest[i]), .cmd_q(cmd[i]), .arg_q(arg[i]));
            assign raddr[i]           = {rd_slot[i*SW +: SW], rd_off[i*OW +: OW]};
            assign rd_data[i*8 +: 8]  = rdata[i];
        end
    endgenerate

    hub_pool_mem #(.AW(AW), .NP(NP)) u_mem (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rdata));

    hub_route_post #(.NSLOTS(NSLOTS), .NP(NP), .DEF_SIZE(DEF_SIZE)) u_route (
        .clk(clk), .rst(rst), .done(done), .slot(slot), .dest(dest), .cmd(cmd),
        .arg(arg), .notify_valid(notify_valid), .notify_slot(notify_slot),
        .rel_mask(route_rel), .size_code(size_code));

    always_comb begin
        rel_mask = route_rel;
        for (int i = 0; i < NP; i++)
            if (tx_done[i]) rel_mask[tx_done_slot[i*SW +: SW]] = 1'b1;
    end

endmodule

// File: tb/switch_hub_test.sv
module switch_hub_test;
    import hub_pkg::*;

    localparam int NP = 4, NSL = 4, NRSV = 1, SW = 2, OW = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NP-1:0]    rx_valid = '0;
    logic [NP*8-1:0]  rx_data = '0;
    logic [NP-1:0]    rx_ready, notify_valid, tx_done = '0;
    logic [SW-1:0]    notify_slot;
    logic [NP*SW-1:0] tx_done_slot = '0, rd_slot = '0;
    logic [NP*OW-1:0] rd_off = '0;
    logic [NP*8-1:0]  rd_data;
    logic             congested;

    switch_hub uut (.clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .notify_valid(notify_valid), .notify_slot(notify_slot),
        .tx_done(tx_done), .tx_done_slot(tx_done_slot), .rd_slot(rd_slot),
        .rd_off(rd_off), .rd_data(rd_data), .congested(congested));

    int checks = 0, failures = 0, cur_len = 64, slot_got = 0;
    bit finished = 1'b0;
    logic [NSL-1:0] model_free = '1;

    task automatic expect_that(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nfree();
        int n = 0;
        for (int s = 0; s < NSL; s++) n += int'(model_free[s]);
        return n;
    endfunction

    function automatic int low_free();
        for (int s = 0; s < NSL; s++) if (model_free[s]) return s;
        return 0;
    endfunction

    function automatic int port_of(input byte_t d);
        return (d >= 8'd1 && d <= 8'd4) ? int'(d) - 1 : 0;
    endfunction

    function automatic byte_t pat(input int k, input byte_t d, input byte_t c,
                                  input byte_t a, input int seed);
        if (k == 0) return d;
        if (k == 1) return c;
        if (k == 2) return a;
        return byte_t'(seed + 3 * k);
    endfunction

    // Sends one packet on port p and checks ready, silence and the notify (R2-R8).
    task automatic send_pkt(input int p, input int len, input byte_t d, input byte_t c,
                            input byte_t a, input int seed, input string req,
                            output int slot_out);
        bit ok;
        int es, bad = 0, early = 0;
        ok = (nfree() > NRSV) || (d == 8'd0 && nfree() > 0);
        es = low_free();
        if (ok) model_free[es] = 1'b0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rx_valid[p] = 1'b1;
            rx_data[p*8 +: 8] = pat(k, d, c, a, seed);
            #1;
            if (rx_ready[p] !== ok) bad++;
            if (notify_valid != '0) early++;
        end
        @(negedge clk);
        rx_valid[p] = 1'b0;
        expect_that(bad == 0, {req, " ready per byte"}, bad, 0);
        expect_that(early == 0 && notify_valid == '0, {req, " no early notify"}, int'(notify_valid), 0);
        @(negedge clk);
        if (ok && d != 8'd0) begin
            expect_that(notify_valid == 4'(1 << port_of(d)), {req, " notify port"},
                        int'(notify_valid), 1 << port_of(d));
            expect_that(int'(notify_slot) == es, {req, " notify slot"}, int'(notify_slot), es);
        end else begin
            expect_that(notify_valid == '0, {req, " silent"}, int'(notify_valid), 0);
        end
        if (ok && d == 8'd0) model_free[es] = 1'b1;
        @(negedge clk);
        expect_that(notify_valid == '0, {req, " strobe one cycle"}, int'(notify_valid), 0);
        slot_out = ok ? es : -1;
    endtask

    task automatic release_slot(input int p, input int s);
        @(negedge clk);
        tx_done[p] = 1'b1;
        tx_done_slot[p*SW +: SW] = SW'(s);
        @(negedge clk);
        tx_done[p] = 1'b0;
        model_free[s] = 1'b1;
    endtask

    task automatic read_chk(input int p, input int s, input int off, input byte_t exp, input string req);
        @(negedge clk);
        rd_slot[p*SW +: SW] = SW'(s);
        rd_off[p*OW +: OW] = OW'(off);
        @(negedge clk);
        expect_that(rd_data[p*8 +: 8] == exp, req, int'(rd_data[p*8 +: 8]), int'(exp));
    endtask

    task automatic congest_chk(input string req);
        @(negedge clk);
        expect_that(congested == (nfree() <= NRSV), req, int'(congested), int'(nfree() <= NRSV));
    endtask

    task automatic test_reset();
        @(negedge clk);
        expect_that(congested == 1'b0, "R1 congested after reset", int'(congested), 0);
        expect_that(notify_valid == '0, "R1 notify after reset", int'(notify_valid), 0);
    endtask

    // R11: two packets start and finish on the same edges.
    task automatic test_pair();
        int sa, sb, bad = 0;
        sa = low_free(); model_free[sa] = 1'b0;
        sb = low_free(); model_free[sb] = 1'b0;
        for (int k = 0; k < cur_len; k++) begin
            @(negedge clk);
            rx_valid[1] = 1'b1; rx_data[15:8]  = pat(k, 8'd4, 8'd7, 8'd0, 11);
            rx_valid[2] = 1'b1; rx_data[23:16] = pat(k, 8'd1, 8'd7, 8'd0, 22);
            #1;
            if (rx_ready[2:1] != 2'b11) bad++;
        end
        @(negedge clk);
        rx_valid = '0;
        expect_that(bad == 0, "R11 both accepted", bad, 0);
        @(negedge clk);
        expect_that(notify_valid == 4'b1000 && int'(notify_slot) == sa,
                    "R11 lower port first", int'(notify_valid), 8);
        @(negedge clk);
        expect_that(notify_valid == 4'b0001 && int'(notify_slot) == sb,
                    "R11 second announce", int'(notify_valid), 1);
        read_chk(3, sa, 9, pat(9, 8'd4, 8'd7, 8'd0, 11), "R2 R11 slot data port1");
        read_chk(0, sb, 9, pat(9, 8'd1, 8'd7, 8'd0, 22), "R2 R11 slot data port2");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        send_pkt(0, 64, 8'd3, 8'd9, 8'd1, 5, "R2 R4 R5 dest3", slot_got);
        expect_that(slot_got == 0, "R2 first slot", slot_got, 0);
        read_chk(2, 0, 5, pat(5, 8'd3, 8'd9, 8'd1, 5), "R2 stored byte 5");
        read_chk(2, 0, 63, pat(63, 8'd3, 8'd9, 8'd1, 5), "R2 stored last byte");
        send_pkt(1, 64, 8'd1, 8'd9, 8'd1, 6, "R5 dest1", slot_got);
        send_pkt(3, 64, 8'd4, 8'd9, 8'd1, 7, "R5 dest4", slot_got);
        congest_chk("R9 only reserve left");
        send_pkt(2, 64, 8'd2, 8'd9, 8'd1, 8, "R3 R8 dropped", slot_got);
        expect_that(slot_got == -1, "R3 no slot", slot_got, -1);
        send_pkt(3, 64, 8'd0, 8'd5, 8'd2, 9, "R6 R8 hub packet", slot_got);
        expect_that(slot_got == 3, "R8 reserved slot used", slot_got, 3);
        congest_chk("R6 R9 reserve returned");
        release_slot(2, 0);
        congest_chk("R9 R10 released");
        send_pkt(1, 64, 8'd9, 8'd9, 8'd1, 10, "R5 R10 fallback reuse", slot_got);
        expect_that(slot_got == 0, "R10 freed slot reused", slot_got, 0);
        release_slot(0, 0);
        release_slot(0, 1);
        release_slot(3, 2);
        congest_chk("R9 all free");
        send_pkt(0, 64, 8'd0, 8'd0, 8'd1, 12, "R7 set 128", slot_got);
        cur_len = 128;
        send_pkt(2, 128, 8'd2, 8'd3, 8'd0, 13, "R7 length 128", slot_got);
        read_chk(1, slot_got, 127, pat(127, 8'd2, 8'd3, 8'd0, 13), "R7 byte 127 stored");
        release_slot(1, slot_got);
        send_pkt(0, 128, 8'd0, 8'd0, 8'd0, 14, "R7 back to 64", slot_got);
        cur_len = 64;
        test_pair();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule